// File: doc/BRIEF.md
# Integer ALU with Carry

A purely combinational 32-bit integer execution unit for a small RISC pipeline. It takes two operands, a 4-bit operation select and the architectural carry flag. It returns a 32-bit result together with the next value of the carry flag, a strobe saying whether the carry flag should be written, and a flag for an operation code it does not recognise.

The unit implements these operations:

- addition, addition with carry in, and subtraction;
- bitwise AND, OR and XOR;
- left shift, logical right shift and arithmetic right shift, each taking a 6-bit amount;
- two single-cycle signed multiplies. One returns the low word of the product. The other returns the high word, even though its encoding slot is the one usually named unsigned.

Only the two add forms update the carry flag. Every other operation passes the incoming carry through unchanged and keeps the strobe low.

The surrounding core decodes immediates, reads the register file and turns the illegal flag into an exception. None of that is inside this unit.

Top module: `alu_int`

## Requirements
- R1: With op_i = 0 (add), result_o equals a_i + b_i modulo 2^32. carry_o is bit 32 of the 33-bit unsigned sum, carry_we_o is 1, and carry_i has no effect.
- R2: With op_i = 1 (add with carry), result_o equals a_i + b_i + carry_i modulo 2^32. carry_o is bit 32 of that full three-input sum, and carry_we_o is 1.
- R3: With op_i = 2 (subtract), result_o equals a_i + ~b_i + 1 modulo 2^32, and carry_we_o is 0.
- R4: With op_i = 3, 4 and 5, result_o is a_i AND b_i, a_i OR b_i and a_i XOR b_i respectively.
- R5: op_i = 6 shifts a_i left, op_i = 7 shifts it right filling with zeros, and op_i = 8 shifts it right filling with a_i[31]. The amount is b_i[5:0], and b_i[31:6] has no effect.
- R6: For shift amounts from 32 to 63, the left and logical right shifts return 0. The arithmetic right shift returns 32 copies of a_i[31].
- R7: With op_i = 9, result_o is bits 31:0 of the signed 64-bit product of a_i and b_i.
- R8: With op_i = 10, result_o is bits 63:32 of the signed 64-bit product, with both operands taken as two's complement.
- R9: For every operation other than add and add with carry, carry_we_o is 0 and carry_o equals carry_i.
- R10: op_i values 11 to 15 set illegal_o to 1, with result_o 0 and carry_we_o 0. Every other op_i value keeps illegal_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; its low 6 bits give the shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Next carry flag value |
| carry_we_o | output | 1 | Carry flag write strobe |
| illegal_o | output | 1 | Unrecognised operation code |

## Verification
Every output is a function of the current inputs alone, so each result is due in the same cycle as its stimulus, with no register anywhere on the path. The bench applies each stimulus on the falling clock edge and samples the outputs a fixed two nanoseconds later. This is well before the next rising edge and after the combinational logic has settled. No check waits on a later clock and none reads the previous cycle's values. The bound checker evaluates its properties continuously on the same signals.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SRA  = 4'd8,
    OP_MUL  = 4'd9,
    OP_MULH = 4'd10
  } alu_op_e;
endpackage

// File: rtl/alu_add.sv
module alu_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W  = 32,
  parameter int SW = 6
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] val_rev;
  logic [W-1:0] out_rev;
  logic [W-1:0] stg [SW+1];
  logic         fill;

  // left shifts reuse the right-shift network on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign val_rev[i] = val_i[W-1-i];
    assign out_rev[i] = stg[SW][W-1-i];
  end

  assign fill   = arith_i & ~left_i & val_i[W-1];
  assign stg[0] = left_i ? val_rev : val_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    if (S >= W) begin : g_flush
      assign stg[k+1] = amt_i[k] ? {W{fill}} : stg[k];
    end else begin : g_part
      assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
    end
  end

  assign res_o = left_i ? out_rev : stg[SW];
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  localparam int PW = 2 * W;
  logic signed [PW-1:0] prod;

  assign prod = PW'($signed(a_i)) * PW'($signed(b_i));
  assign lo_o = prod[W-1:0];
  assign hi_o = prod[PW-1:W];
endmodule

// File: rtl/alu_int.sv
module alu_int
  import alu_int_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_we_o,
  output logic              illegal_o
);
  localparam int SHAMT_W = $clog2(DATA_W) + 1;

  alu_op_e           op;
  logic              is_sub;
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              add_cout;
  logic [DATA_W-1:0] sh_res;
  logic              sh_left;
  logic              sh_arith;
  logic [DATA_W-1:0] mul_lo;
  logic [DATA_W-1:0] mul_hi;

  assign op       = alu_op_e'(op_i);
  assign is_sub   = (op == OP_SUB);
  assign add_cin  = is_sub | ((op == OP_ADDC) & carry_i);
  assign sh_left  = (op == OP_SLL);
  assign sh_arith = (op == OP_SRA);

  alu_add #(.W(DATA_W)) u_add (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_cout)
  );

  alu_shift #(.W(DATA_W), .SW(SHAMT_W)) u_shift (
    .val_i  (a_i),
    .amt_i  (b_i[SHAMT_W-1:0]),
    .left_i (sh_left),
    .arith_i(sh_arith),
    .res_o  (sh_res)
  );

  alu_mul #(.W(DATA_W)) u_mul (
    .a_i (a_i),
    .b_i (b_i),
    .lo_o(mul_lo),
    .hi_o(mul_hi)
  );

  always_comb begin
    result_o   = '0;
    carry_o    = carry_i;
    carry_we_o = 1'b0;
    illegal_o  = 1'b0;
    case (op)
      OP_ADD, OP_ADDC: begin
        result_o   = add_sum;
        carry_o    = add_cout;
        carry_we_o = 1'b1;
      end
      OP_SUB:                 result_o = add_sum;
      OP_AND:                 result_o = a_i & b_i;
      OP_OR:                  result_o = a_i | b_i;
      OP_XOR:                 result_o = a_i ^ b_i;
      OP_SLL, OP_SRL, OP_SRA: result_o = sh_res;
      OP_MUL:                 result_o = mul_lo;
      OP_MULH:                result_o = mul_hi;
      default:                illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_int_chk.sv
module alu_int_chk #(
  parameter int DATA_W = 32
) (
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              carry_we_o,
  input logic              illegal_o
);
  logic [DATA_W:0] ref_sum;
  logic            known;

  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, (op_i == 4'd1) & carry_i};
  assign known   = !$isunknown({op_i, a_i, b_i, carry_i});

  always_comb begin
    if (known) begin
      // R1
      a_r1_add: assert (op_i != 4'd0 || ({carry_o, result_o} == ref_sum && carry_we_o))
        else $error("add result/carry wrong");
      // R2
      a_r2_addc: assert (op_i != 4'd1 || ({carry_o, result_o} == ref_sum && carry_we_o))
        else $error("add-with-carry result/carry wrong");
      // R3
      a_r3_sub: assert (op_i != 4'd2 || (result_o == DATA_W'(a_i - b_i) && !carry_we_o))
        else $error("subtract wrong");
      // R6
      a_r6_wide_srl: assert (!(op_i == 4'd7 && b_i[5]) || result_o == '0)
        else $error("wide logical right shift not zero");
      // R9
      a_r9_carry_hold: assert (carry_we_o || carry_o == carry_i)
        else $error("carry changed without write strobe");
      // R10
      a_r10_illegal: assert ((op_i > 4'd10) == illegal_o &&
                             (!illegal_o || (result_o == '0 && !carry_we_o)))
        else $error("illegal op handling wrong");
    end
  end
endmodule

bind alu_int alu_int_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .carry_i   (carry_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .carry_we_o(carry_we_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_alu_int.sv
`timescale 1ns/1ps
module tb_alu_int;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  logic        carry_we_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  alu_int dut (
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .carry_we_o(carry_we_o),
    .illegal_o (illegal_o)
  );

  // {op, a, b, carry_in, result, carry_out, carry_we, illegal, req}
  localparam int NV = 26;
  localparam logic [107:0] VECS [NV] = '{
    {4'd0,  32'h00000005, 32'h00000003, 1'b0, 32'h00000008, 1'b0, 1'b1, 1'b0, 4'd1},  // R1
    {4'd0,  32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd1},  // R1
    {4'd0,  32'h80000000, 32'h80000000, 1'b1, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 carry_i ignored
    {4'd1,  32'h00000001, 32'h00000002, 1'b1, 32'h00000004, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
    {4'd1,  32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 carry from cin
    {4'd1,  32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 4'd2},  // R2
    {4'd2,  32'h00000010, 32'h00000003, 1'b1, 32'h0000000D, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    {4'd2,  32'h00000003, 32'h00000005, 1'b0, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    {4'd3,  32'hF0F0F0F0, 32'hFF00FF00, 1'b1, 32'hF000F000, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 R9
    {4'd4,  32'h12340000, 32'h00005678, 1'b0, 32'h12345678, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    {4'd5,  32'hAAAAAAAA, 32'hFFFF0000, 1'b1, 32'h5555AAAA, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 R9
    {4'd6,  32'h00000001, 32'h00000044, 1'b0, 32'h00000010, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 b[6] ignored
    {4'd7,  32'h80000000, 32'hFFFFFFC1, 1'b1, 32'h40000000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 R9
    {4'd8,  32'h80000000, 32'h00000004, 1'b0, 32'hF8000000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    {4'd6,  32'h00000001, 32'h0000001F, 1'b0, 32'h80000000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    {4'd6,  32'h00000001, 32'h00000020, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    {4'd7,  32'hFFFFFFFF, 32'h0000003F, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    {4'd8,  32'h80000000, 32'h00000028, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    {4'd8,  32'h7FFFFFFF, 32'h00000020, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    {4'd9,  32'h00000007, 32'hFFFFFFFD, 1'b1, 32'hFFFFFFEB, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 R9
    {4'd9,  32'h00010000, 32'h00010000, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    {4'd10, 32'h00010000, 32'h00010000, 1'b0, 32'h00000001, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    {4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 signed
    {4'd10, 32'h80000000, 32'h00000002, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
    {4'd11, 32'h12345678, 32'h00000001, 1'b1, 32'h00000000, 1'b1, 1'b0, 1'b1, 4'd10}, // R10
    {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b1, 4'd10}  // R10
  };

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic ci);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; carry_i = ci;
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic eco,
                       input logic ewe, input logic eil);
    n_chk++;
    if (result_o !== er || carry_o !== eco || carry_we_o !== ewe || illegal_o !== eil) begin
      n_bad++;
      $display("FAIL %s op=%0d: got res=%h co=%b we=%b il=%b exp res=%h co=%b we=%b il=%b",
               req, op_i, result_o, carry_o, carry_we_o, illegal_o, er, eco, ewe, eil);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // idle state: all-zero inputs select add of zeros (R1, R10)
    #2;
    check("R1", 32'h0, 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [107:0] v;
      v = VECS[i];
      apply(v[107:104], v[103:72], v[71:40], v[39]);
      check($sformatf("R%0d", v[3:0]), v[38:7], v[6], v[5], v[4]);
    end

    // R5 R6: left shift sweep of all 64 amounts, upper b bits set
    for (int s = 0; s < 64; s++) begin
      apply(4'd6, 32'h00000001, {26'h3FFFFFF, 6'(s)}, 1'b1);
      check("R6", (s < 32) ? (32'h1 << s) : 32'h0, 1'b1, 1'b0, 1'b0);
    end

    // R6: arithmetic right shift sweep of a negative operand
    for (int s = 0; s < 64; s++) begin
      apply(4'd8, 32'h80000000, 32'(s), 1'b0);
      check("R6", ~(32'hFFFFFFFF >> (s + 1)), 1'b0, 1'b0, 1'b0);
    end

    // R10: every illegal code, both carry values
    for (int o = 11; o < 16; o++) begin
      apply(4'(o), 32'hDEADBEEF, 32'h00000003, o[0]);
      check("R10", 32'h0, o[0], 1'b0, 1'b1);
    end

    // R9: subtract with borrow-like overflow still holds carry
    apply(4'd2, 32'h00000000, 32'h00000001, 1'b1);
    check("R9", 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end
endmodule